// File: doc/BRIEF.md
# Paged Program Sequencer with Two-Level Return Stack

This block steps through the program of a small 4-bit controller. It holds a 9-bit program counter that addresses a ROM of eight 64-word pages. It also holds two return-address registers, SA (top) and SB (bottom). Each instruction cycle it receives a decoded control-transfer code, the operand field, the accumulator nibble, the RAM nibble and a one-cycle skip flag. From these it computes the next program address.

Jump-indirect and indirect-load take two cycles. In the first cycle the block presents an indirect ROM address with a strobe. The ROM answers with a byte in the second cycle, and the block uses that byte to set the low PC bits or its 8-bit table-lookup latch. A return-and-skip raises a skip request for the following instruction.

The decoder drives `op` with one of these codes: 0 = sequential, 1 = long jump, 2 = page-relative jump, 3 = subroutine-page call, 4 = full call, 5 = return, 6 = return-and-skip, 7 = jump-indirect, 8 = indirect-load. Codes 9 to 15 behave as code 0.

Top module: `prog_sequencer`

## Requirements
- R1: While `rst_n` is low, the PC, SA, SB and the lookup latch clear to zero, and `skip_out` and `ind_strobe` stay low. A return issued straight after reset therefore lands on address 0.
- R2: A sequential instruction sets the PC to PC+1 modulo 512. The count runs straight across page boundaries, so 0x03F goes to 0x040 and 0x1FF goes to 0x000.
- R3: A long jump (code 1) loads all 9 bits of `operand` into the PC.
- R4: A page-relative jump (code 2) looks at the incremented PC. If that value lies in page 2 or 3, bits 6:0 of the PC come from `operand[6:0]`. Otherwise only bits 5:0 come from `operand[5:0]`. The remaining upper bits come from the incremented PC.
- R5: A subroutine-page call (code 3) pushes PC+1 into SA and the old SA into SB. It then sets the PC to {3'b010, `operand[5:0]`}.
- R6: A full call (code 4) pushes the stack the same way and loads `operand[8:0]` into the PC.
- R7: A return (code 5) loads SA into the PC and SB into SA.
- R8: A return-and-skip (code 6) does the same as a return and holds `skip_out` high for exactly the following instruction cycle.
- R9: Jump-indirect (code 7) drives `ind_addr` = {bit 8 of PC+1, `acc`, `ram_nib`} with `ind_strobe` high in its first cycle. `op` is ignored in the second cycle. At the end of the second cycle the PC becomes {bit 8 of PC+1, `rom_data`}.
- R10: Indirect-load (code 8) drives the same address and strobe. At the end of its second cycle it loads `rom_data` into `q_out` and sets the PC to PC+1. SA is unchanged and SB takes the old SA.
- R11: When `skip_in` is high on a single-cycle slot, the operation has no effect except PC+1. There is no strobe, no stack change, no latch change and no skip request, and a skipped indirect operation takes one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Decoded control-transfer code |
| operand | input | 9 | Immediate target field |
| acc | input | 4 | Accumulator nibble |
| ram_nib | input | 4 | Addressed RAM nibble |
| rom_data | input | 8 | ROM byte returned one cycle after a strobe |
| skip_in | input | 1 | Suppress the current instruction |
| fetch_addr | output | 9 | Current program counter |
| ind_addr | output | 9 | Indirect ROM address |
| ind_strobe | output | 1 | Indirect fetch request |
| skip_out | output | 1 | Skip request for the next instruction |
| q_out | output | 8 | Table-lookup latch |

## Verification
Single-cycle operations show their new PC on `fetch_addr` one clock edge after the slot in which they are driven. The skip request from a return-and-skip is visible during that same following cycle. The indirect address and strobe are combinational, so the bench checks them within the issuing cycle. The indirect operations' PC and latch results are due two edges after issue. The bench drives inputs and samples outputs on falling edges, and it counts edges per scenario so that each comparison falls on the cycle its result is due. Stack contents are read back through chains of returns.

// File: rtl/prog_sequencer.sv
module prog_sequencer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op,
  input  logic [8:0] operand,
  input  logic [3:0] acc,
  input  logic [3:0] ram_nib,
  input  logic [7:0] rom_data,
  input  logic       skip_in,
  output logic [8:0] fetch_addr,
  output logic [8:0] ind_addr,
  output logic       ind_strobe,
  output logic       skip_out,
  output logic [7:0] q_out
);
  localparam logic [3:0] OP_JMP  = 4'd1;
  localparam logic [3:0] OP_JP   = 4'd2;
  localparam logic [3:0] OP_JSRP = 4'd3;
  localparam logic [3:0] OP_JSR  = 4'd4;
  localparam logic [3:0] OP_RET  = 4'd5;
  localparam logic [3:0] OP_RETS = 4'd6;
  localparam logic [3:0] OP_JID  = 4'd7;
  localparam logic [3:0] OP_LQ   = 4'd8;

  logic [8:0] pc, sa, sb;
  logic [7:0] q;
  logic       busy, pend_lq, skip_q;

  wire [8:0] pc_inc   = pc + 9'd1;
  wire       live     = !busy && !skip_in;
  wire       wide_pg  = (pc_inc[8:7] == 2'b01);

  assign ind_strobe = live && (op == OP_JID || op == OP_LQ);
  assign ind_addr   = {pc_inc[8], acc, ram_nib};
  assign fetch_addr = pc;
  assign skip_out   = skip_q;
  assign q_out      = q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; sa <= '0; sb <= '0; q <= '0;
      busy <= 1'b0; pend_lq <= 1'b0; skip_q <= 1'b0;
    end else if (busy) begin
      busy   <= 1'b0;
      skip_q <= 1'b0;
      if (pend_lq) begin
        q  <= rom_data;
        pc <= pc_inc;
      end else begin
        pc <= {pc_inc[8], rom_data};
      end
    end else begin
      skip_q  <= 1'b0;
      busy    <= ind_strobe;
      pend_lq <= (op == OP_LQ);
      if (skip_in) pc <= pc_inc;
      else begin
        case (op)
          OP_JMP: pc <= operand;
          OP_JP:  pc <= wide_pg ? {pc_inc[8:7], operand[6:0]}
                                : {pc_inc[8:6], operand[5:0]};
          OP_JSRP: begin
            sa <= pc_inc; sb <= sa; pc <= {3'b010, operand[5:0]};
          end
          OP_JSR: begin
            sa <= pc_inc; sb <= sa; pc <= operand;
          end
          OP_RET: begin
            pc <= sa; sa <= sb;
          end
          OP_RETS: begin
            pc <= sa; sa <= sb; skip_q <= 1'b1;
          end
          OP_JID: ;
          OP_LQ:  sb <= sa;
          default: pc <= pc_inc;
        endcase
      end
    end
  end

  assert_jmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op == OP_JMP) |=> fetch_addr == $past(operand));
  assert_call_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op == OP_JSRP) |=> (fetch_addr[8:6] == 3'b010 && sa == $past(fetch_addr) + 9'd1));
  assert_skip_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op == OP_RETS) |=> skip_out);
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ind_strobe |=> !ind_strobe);
  assert_lookup_stack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_strobe && op == OP_LQ) |=> sb == $past(sa));
  assert_skipped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && skip_in) |=> (fetch_addr == $past(fetch_addr) + 9'd1 && !skip_out));
endmodule

// File: tb/prog_sequencer_bench.sv
module prog_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [8:0] operand = '0;
  logic [3:0] acc = '0, ram_nib = '0;
  logic [7:0] rom_data = '0;
  logic       skip_in = 1'b0;
  logic [8:0] fetch_addr, ind_addr;
  logic       ind_strobe, skip_out;
  logic [7:0] q_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  prog_sequencer u_prog_sequencer (
    .clk(clk), .rst_n(rst_n), .op(op), .operand(operand), .acc(acc),
    .ram_nib(ram_nib), .rom_data(rom_data), .skip_in(skip_in),
    .fetch_addr(fetch_addr), .ind_addr(ind_addr), .ind_strobe(ind_strobe),
    .skip_out(skip_out), .q_out(q_out));

  function automatic logic [7:0] rom_val(input logic [8:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd7 + 16'd3;
    return t[7:0] ^ 8'h5C;
  endfunction

  always_ff @(posedge clk) if (ind_strobe) rom_data <= rom_val(ind_addr);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [8:0] v);
    op = o; operand = v;
    @(negedge clk);
    op = 4'd0; operand = '0;
  endtask

  task automatic t_reset;
    check("R1", {7'd0, fetch_addr}, 16'h000);
    check("R1", {8'd0, q_out}, 16'h00);
    check("R1", {14'd0, skip_out, ind_strobe}, 16'h0);
    issue(4'd5, 9'd0);
    check("R1", {7'd0, fetch_addr}, 16'h000);
  endtask

  task automatic t_increment;
    issue(4'd1, 9'h03F); issue(4'd0, 9'd0);
    check("R2", {7'd0, fetch_addr}, 16'h040);
    issue(4'd1, 9'h1FF); issue(4'd12, 9'h155);
    check("R2", {7'd0, fetch_addr}, 16'h000);
  endtask

  task automatic t_jump;
    issue(4'd1, 9'h155);
    check("R3", {7'd0, fetch_addr}, 16'h155);
  endtask

  task automatic t_page_jump;
    issue(4'd1, 9'h0A0); issue(4'd2, 9'h1FF);
    check("R4", {7'd0, fetch_addr}, 16'h0FF);
    issue(4'd1, 9'h050); issue(4'd2, 9'h1FF);
    check("R4", {7'd0, fetch_addr}, 16'h07F);
    issue(4'd1, 9'h07F); issue(4'd2, 9'h1FF);
    check("R4", {7'd0, fetch_addr}, 16'h0FF);
    issue(4'd1, 9'h0D0); issue(4'd2, 9'h005);
    check("R4", {7'd0, fetch_addr}, 16'h085);
    issue(4'd1, 9'h1BF); issue(4'd2, 9'h07F);
    check("R4", {7'd0, fetch_addr}, 16'h1FF);
  endtask

  task automatic t_calls;
    issue(4'd1, 9'h123); issue(4'd3, 9'h02A);
    check("R5", {7'd0, fetch_addr}, 16'h0AA);
    issue(4'd4, 9'h1F0);
    check("R6", {7'd0, fetch_addr}, 16'h1F0);
    issue(4'd5, 9'd0);
    check("R7", {7'd0, fetch_addr}, 16'h0AB);
    issue(4'd6, 9'd0);
    check("R8", {7'd0, fetch_addr}, 16'h124);
    check("R8", {15'd0, skip_out}, 16'h1);
    issue(4'd0, 9'd0);
    check("R8", {15'd0, skip_out}, 16'h0);
  endtask

  task automatic t_jump_indirect;
    issue(4'd1, 9'h1C0);
    acc = 4'h3; ram_nib = 4'hA; op = 4'd7;
    #1;
    check("R9", {7'd0, ind_addr}, 16'h13A);
    check("R9", {15'd0, ind_strobe}, 16'h1);
    @(negedge clk);
    op = 4'd1; operand = 9'h000;
    #1;
    check("R9", {15'd0, ind_strobe}, 16'h0);
    @(negedge clk);
    op = 4'd0; operand = '0;
    check("R9", {7'd0, fetch_addr}, {7'd0, 1'b1, rom_val(9'h13A)});
  endtask

  task automatic t_lookup;
    issue(4'd1, 9'h010); issue(4'd4, 9'h020); issue(4'd4, 9'h030);
    acc = 4'h5; ram_nib = 4'h6; op = 4'd8;
    #1;
    check("R10", {7'd0, ind_addr}, 16'h056);
    @(negedge clk);
    op = 4'd0;
    @(negedge clk);
    check("R10", {8'd0, q_out}, {8'd0, rom_val(9'h056)});
    check("R10", {7'd0, fetch_addr}, 16'h031);
    issue(4'd5, 9'd0);
    check("R10", {7'd0, fetch_addr}, 16'h021);
    issue(4'd5, 9'd0);
    check("R10", {7'd0, fetch_addr}, 16'h021);
  endtask

  task automatic t_skip;
    logic [7:0] q_before;
    q_before = q_out;
    issue(4'd1, 9'h040); issue(4'd4, 9'h0E0);
    skip_in = 1'b1;
    issue(4'd1, 9'h100);
    check("R11", {7'd0, fetch_addr}, 16'h0E1);
    acc = 4'hF; ram_nib = 4'hF; op = 4'd8;
    #1;
    check("R11", {15'd0, ind_strobe}, 16'h0);
    @(negedge clk);
    op = 4'd0;
    check("R11", {7'd0, fetch_addr}, 16'h0E2);
    check("R11", {8'd0, q_out}, {8'd0, q_before});
    issue(4'd4, 9'h111);
    issue(4'd6, 9'd0);
    check("R11", {15'd0, skip_out}, 16'h0);
    check("R11", {7'd0, fetch_addr}, 16'h0E4);
    skip_in = 1'b0;
    issue(4'd5, 9'd0);
    check("R11", {7'd0, fetch_addr}, 16'h041);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_increment();
    t_jump();
    t_page_jump();
    t_calls();
    t_jump_indirect();
    t_lookup();
    t_skip();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule